// File: doc/BRIEF.md
# Strided-Increment Microcode Address Sequencer

This block chooses the next microcode address of a microprogrammed processor on every cycle. The next address comes from one of five places: a sequential step, a target field in the current microword (jump or subroutine call), the top of a six-entry return stack, an address computed by the datapath (case branch), or an entry point decoded by fixed logic from the next macro-instruction register. The block also hands the execution stage the microword for the current cycle. Normally this is the line fetched from external control store. An on-chip ROM supplies it instead when the address falls in the ROM window, or when the previous line asked for a ROM line by index.

The sequential step has two sizes. Below the end of a low region of 3072 words, the step is one 512-word block. Each of the 512 dispatch entry points therefore owns one line in each of six blocks, and no instruction needs a branch on its first line. At or above the region end, the step is one word. All branches take effect one line late. The line in the delay slot always issues, but it can be turned into a no-op when the branch is not taken.

Top module: `skip_useq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, upc_o is 0, squash_o is 0 and both error flags are 0. The return stack is empty and no branch is pending.
- R2: The microword fields are as follows. Bits [2:0] are the op: 0 sequential, 1 jump, 2 call, 3 return, 4 case, 5 dispatch, 6 and 7 sequential. Bits [7:3] select a test input. Bit 8 inverts the test. Bit 9 is annul. Bit 10 is index enable. Bits [18:11] are the ROM index. Bits [32:19] are the target. A branch op is taken when cond_i[select] XOR invert is 1.
- R3: With no taken branch landing, the next upc_o is upc_o+512 while upc_o < 3072, and upc_o+1 when upc_o >= 3072 (modulo 2^14).
- R4: Suppose a branch op is decoded in cycle t with upc_o = A. In cycle t+1, upc_o is the sequential successor of A. In cycle t+2, upc_o is the branch address if the branch was taken, and the sequential successor of A's successor if it was not.
- R5: A jump or call goes to the target field. A case goes to case_addr_i, sampled in cycle t. A dispatch goes to an entry point decoded from next_ir_i in cycle t. If next_ir_i[15:13] is 3'b111, the entry is {3'b111, next_ir_i[6:2], next_ir_i[1]^next_ir_i[0]}. Otherwise it is next_ir_i[15:7].
- R6: If the branch line has annul set and the branch is not taken, the delay-slot line shows squash_o = 1 and has no effect: no branch and no ROM index.
- R7: A taken call pushes the sequential successor of its delay-slot address. A taken return jumps to the most recent pushed value and removes it. The stack holds six entries in LIFO order.
- R8: A taken call with six entries held is discarded and sets ovf_err_o. A taken return on an empty stack goes to address 0 and sets unf_err_o. Both flags stay set until reset.
- R9: A line with index enable set, and not squashed, makes the next cycle's uword_o the ROM word at that index. upc_o still advances exactly as it would without the index, and the stack is untouched. An index of 160 or more gives an all-zero word.
- R10: When upc_o >= 16224, uword_o is ROM word (upc_o − 16224). Otherwise, with no index overlay pending, uword_o equals ext_word_i.
- R11: ROM word k has bits [53:46] = k, bits [45:38] = ~k, and all other bits 0.
- R12: Branch ops in a delay-slot line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_word_i | input | 54 | Line read from external control store at upc_o |
| cond_i | input | 32 | Branch test inputs |
| case_addr_i | input | 14 | Datapath-computed case target |
| next_ir_i | input | 16 | Next macro-instruction register |
| upc_o | output | 14 | Current microcode address |
| uword_o | output | 54 | Effective microword for this cycle |
| squash_o | output | 1 | Current line is annulled |
| ovf_err_o | output | 1 | Sticky return-stack overflow |
| unf_err_o | output | 1 | Sticky return-stack underflow |

## Verification
The assertions check on every cycle that:
- a non-branching cycle steps by the region-dependent stride;
- a taken branch lands exactly two lines after it is decoded;
- a delay slot never opens another delay slot;
- squash appears only in a delay slot;
- stack occupancy never exceeds six;
- the error flags never clear on their own.

The directed scenarios are the only way to show which address each source actually produces. That covers jump, case, the two dispatch decode classes, and LIFO return order across nested calls. The scenarios also show the discarded push on overflow, the zero target on underflow, ROM word contents under index overlay and in the ROM window, and the micro-PC continuing undisturbed under an overlay.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UW_W  = 54;
  localparam int IDX_W = 8;
  localparam int SEL_W = 5;

  localparam logic [2:0] OP_SEQ  = 3'd0;
  localparam logic [2:0] OP_JMP  = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;
  localparam logic [2:0] OP_CASE = 3'd4;
  localparam logic [2:0] OP_DISP = 3'd5;

  function automatic logic [UW_W-1:0] rom_word(input int k);
    logic [UW_W-1:0] w;
    logic [7:0] kb;
    kb = k[7:0];
    w = '0;
    w[53:46] = kb;
    w[45:38] = ~kb;
    return w;
  endfunction

  // fixed opcode-to-entry decode
  function automatic logic [8:0] entry_of(input logic [15:0] ir);
    if (ir[15:13] == 3'b111) return {3'b111, ir[6:2], ir[1] ^ ir[0]};
    else                     return ir[15:7];
  endfunction
endpackage

// File: rtl/useq_incr.sv
module useq_incr #(
  parameter int ADDR_W    = 14,
  parameter int STRIDE_LG = 9,
  parameter int SKIP_END  = 3072
) (
  input  logic [ADDR_W-1:0] upc_i,
  output logic [ADDR_W-1:0] seq_o
);
  logic [ADDR_W-1:0] carry;
  // one incrementer, carry injected at bit STRIDE_LG or bit 0
  always_comb begin
    carry = (upc_i < ADDR_W'(SKIP_END)) ? (ADDR_W'(1) << STRIDE_LG) : ADDR_W'(1);
    seq_o = upc_i + carry;
  end
endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int DEPTH = 6,
  parameter int W     = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          ovf_q, unf_q;
  logic          full, empty;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign top_o = empty ? '0 : mem_q[cnt_q - 1'b1];
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      if (full) ovf_q <= 1'b1;
      else begin
        mem_q[cnt_q] <= din_i;
        cnt_q        <= cnt_q + 1'b1;
      end
    end else if (pop_i) begin
      if (empty) unf_q <= 1'b1;
      else       cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_depth_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  assert_unf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |=> unf_q);
endmodule

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int WORDS = 160,
  parameter int W     = 54,
  parameter int AW    = 8
) (
  input  logic [AW-1:0] addr_i,
  output logic [W-1:0]  word_o
);
  logic [W-1:0] rom [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_rom
    assign rom[g] = useq_pkg::rom_word(g);
  end

  always_comb word_o = (addr_i < AW'(WORDS)) ? rom[addr_i] : '0;
endmodule

// File: rtl/skip_useq.sv
module skip_useq
  import useq_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int STRIDE_LG   = 9,
  parameter int SKIP_END    = 3072,
  parameter int NCOND       = 32,
  parameter int STACK_DEPTH = 6,
  parameter int ROM_WORDS   = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [UW_W-1:0]   ext_word_i,
  input  logic [NCOND-1:0]  cond_i,
  input  logic [ADDR_W-1:0] case_addr_i,
  input  logic [15:0]       next_ir_i,
  output logic [ADDR_W-1:0] upc_o,
  output logic [UW_W-1:0]   uword_o,
  output logic              squash_o,
  output logic              ovf_err_o,
  output logic              unf_err_o
);
  localparam int ROM_BASE = (1 << ADDR_W) - ROM_WORDS;
  localparam int STRIDE   = 1 << STRIDE_LG;

  logic [ADDR_W-1:0] upc_q, pend_addr_q;
  logic              slot_q, squash_q, pend_taken_q, ovl_q;
  logic [IDX_W-1:0]  ovl_idx_q;

  logic [ADDR_W-1:0] seq_a, seq_b, tgt, stk_top, next_upc;
  logic [IDX_W-1:0]  rom_addr;
  logic [UW_W-1:0]   rom_data;
  logic              rom_sel;

  logic [2:0]        f_op;
  logic [SEL_W-1:0]  f_sel;
  logic              f_inv, f_annul, f_idx_en;
  logic [IDX_W-1:0]  f_idx;
  logic [ADDR_W-1:0] f_tgt;
  logic              is_br, cond_hit, taken, do_push, do_pop, idx_go;

  useq_incr #(.ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG), .SKIP_END(SKIP_END))
    u_inc_a (.upc_i(upc_q), .seq_o(seq_a));
  useq_incr #(.ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG), .SKIP_END(SKIP_END))
    u_inc_b (.upc_i(seq_a), .seq_o(seq_b));

  useq_rom #(.WORDS(ROM_WORDS), .W(UW_W), .AW(IDX_W))
    u_rom (.addr_i(rom_addr), .word_o(rom_data));

  useq_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stk (
    .clk_i, .rst_ni, .push_i(do_push), .pop_i(do_pop), .din_i(seq_b),
    .top_o(stk_top), .ovf_o(ovf_err_o), .unf_o(unf_err_o));

  // word select: index overlay wins, then ROM window, then control store
  always_comb begin
    rom_sel  = ovl_q || (upc_q >= ADDR_W'(ROM_BASE));
    rom_addr = ovl_q ? ovl_idx_q : IDX_W'(upc_q - ADDR_W'(ROM_BASE));
    uword_o  = rom_sel ? rom_data : ext_word_i;
  end

  always_comb begin
    f_op     = uword_o[2:0];
    f_sel    = uword_o[7:3];
    f_inv    = uword_o[8];
    f_annul  = uword_o[9];
    f_idx_en = uword_o[10];
    f_idx    = uword_o[18:11];
    f_tgt    = uword_o[19 +: ADDR_W];

    is_br    = !slot_q && (f_op inside {OP_JMP, OP_CALL, OP_RET, OP_CASE, OP_DISP});
    cond_hit = cond_i[f_sel] ^ f_inv;
    taken    = is_br && cond_hit;
    do_push  = taken && (f_op == OP_CALL);
    do_pop   = taken && (f_op == OP_RET);
    idx_go   = !squash_q && f_idx_en;

    case (f_op)
      OP_JMP, OP_CALL: tgt = f_tgt;
      OP_RET:          tgt = stk_top;
      OP_CASE:         tgt = case_addr_i;
      OP_DISP:         tgt = ADDR_W'(entry_of(next_ir_i));
      default:         tgt = seq_b;
    endcase

    next_upc = (slot_q && pend_taken_q) ? pend_addr_q : seq_a;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upc_q        <= '0;
      slot_q       <= 1'b0;
      squash_q     <= 1'b0;
      pend_taken_q <= 1'b0;
      pend_addr_q  <= '0;
      ovl_q        <= 1'b0;
      ovl_idx_q    <= '0;
    end else begin
      upc_q        <= next_upc;
      slot_q       <= is_br;
      squash_q     <= is_br && f_annul && !cond_hit;
      pend_taken_q <= taken;
      pend_addr_q  <= tgt;
      ovl_q        <= idx_go;
      ovl_idx_q    <= f_idx;
    end
  end

  assign upc_o    = upc_q;
  assign squash_o = squash_q;

  assert_seq_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(slot_q && pend_taken_q)) |->
      upc_q == $past(upc_q) + (($past(upc_q) < ADDR_W'(SKIP_END)) ?
                               ADDR_W'(STRIDE) : ADDR_W'(1)));
  assert_branch_land_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(slot_q && pend_taken_q)) |-> upc_q == $past(pend_addr_q));
  assert_squash_in_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_q |-> slot_q);
  assert_no_slot_chain_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q |=> !slot_q);
endmodule

// File: tb/skip_useq_tb.sv
module skip_useq_tb;
  localparam int CLK_NS = 10;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [53:0] ext_word_i;
  logic [31:0] cond_i = 32'h1;
  logic [13:0] case_addr_i = '0;
  logic [15:0] next_ir_i = '0;
  logic [13:0] upc_o;
  logic [53:0] uword_o;
  logic        squash_o, ovf_err_o, unf_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [13:0] p_addr [NP];
  logic [53:0] p_word [NP];
  logic        p_vld  [NP];

  always #(CLK_NS/2) clk = ~clk;

  skip_useq u_dut (
    .clk_i(clk), .rst_ni, .ext_word_i, .cond_i, .case_addr_i, .next_ir_i,
    .upc_o, .uword_o, .squash_o, .ovf_err_o, .unf_err_o);

  always_comb begin
    ext_word_i = '0;
    for (int i = 0; i < NP; i++)
      if (p_vld[i] && p_addr[i] == upc_o) ext_word_i = p_word[i];
  end

  function automatic logic [53:0] mk(input logic [2:0] op, input int sel, input bit inv,
                                     input bit ann, input bit ie, input int idx, input int tgt);
    logic [53:0] w;
    w = '0;
    w[2:0]   = op;
    w[7:3]   = sel[4:0];
    w[8]     = inv;
    w[9]     = ann;
    w[10]    = ie;
    w[18:11] = idx[7:0];
    w[32:19] = tgt[13:0];
    return w;
  endfunction

  function automatic logic [53:0] exp_rom(input int k);
    logic [7:0] kb;
    kb = k[7:0];
    if (k >= 160) return '0;
    return {kb, ~kb, 38'b0};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int s, input int a, input logic [53:0] w);
    p_addr[s] = a[13:0];
    p_word[s] = w;
    p_vld[s]  = 1'b1;
  endtask

  task automatic do_reset();
    for (int i = 0; i < NP; i++) begin p_vld[i] = 0; p_addr[i] = '0; p_word[i] = '0; end
    cond_i = 32'h1; case_addr_i = '0; next_ir_i = '0;
    rst_ni = 1'b0;
    step(); step();
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    step(); step(); step();
    rst_ni = 1'b0;
    #1;
    chk("R1", "upc in reset", upc_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R1", "upc", upc_o, 0);
    chk("R1", "squash", squash_o, 0);
    chk("R1", "ovf", ovf_err_o, 0);
    chk("R1", "unf", unf_err_o, 0);
  endtask

  task automatic t_seq();
    int e;
    do_reset();
    e = 0;
    for (int i = 0; i < 9; i++) begin
      chk("R3", "seq upc", upc_o, e);
      e = (e < 3072) ? e + 512 : e + 1;
      step();
    end
  endtask

  task automatic t_jump();
    do_reset();
    put(0, 0, mk(3'd1, 0, 0, 0, 0, 0, 4000));
    chk("R4", "jump t", upc_o, 0); step();
    chk("R4", "jump slot", upc_o, 512); step();
    chk("R4", "jump land", upc_o, 4000); step();
    chk("R3", "after region +1", upc_o, 4001);
    do_reset();
    put(0, 0, mk(3'd1, 17, 0, 0, 0, 0, 4000));
    step(); step();
    chk("R2", "cond false not taken", upc_o, 1024);
    do_reset();
    put(0, 0, mk(3'd1, 17, 1, 0, 0, 0, 4000));
    step(); step();
    chk("R2", "inverted cond taken", upc_o, 4000);
  endtask

  task automatic t_annul();
    do_reset();
    put(0, 0, mk(3'd1, 17, 0, 1, 0, 0, 4000));
    put(1, 512, mk(3'd1, 0, 0, 0, 1, 9, 6000));
    step();
    chk("R6", "annulled slot squash", squash_o, 1);
    step();
    chk("R6", "squashed slot no effect upc", upc_o, 1024);
    chk("R6", "squashed slot no index", uword_o, 0);
    chk("R6", "squash cleared", squash_o, 0);
    do_reset();
    cond_i = 32'h0002_0001;
    put(0, 0, mk(3'd1, 17, 0, 1, 0, 0, 4000));
    put(1, 512, mk(3'd1, 0, 0, 0, 0, 0, 6000));
    step();
    chk("R6", "taken keeps slot", squash_o, 0);
    step();
    chk("R12", "slot branch ignored", upc_o, 4000);
    step();
    chk("R12", "continues seq", upc_o, 4001);
  endtask

  task automatic t_sources();
    do_reset();
    case_addr_i = 14'd7000;
    put(0, 0, mk(3'd4, 0, 0, 0, 0, 0, 0));
    step(); step();
    chk("R5", "case target", upc_o, 7000);
    do_reset();
    next_ir_i = 16'h0A80;
    put(0, 0, mk(3'd5, 0, 0, 0, 0, 0, 0));
    step(); step();
    chk("R5", "dispatch normal class", upc_o, 21);
    step();
    chk("R3", "entry strided", upc_o, 533);
    do_reset();
    next_ir_i = 16'hE00D;
    put(0, 0, mk(3'd5, 0, 0, 0, 0, 0, 0));
    step(); step();
    chk("R5", "dispatch top class", upc_o, 455);
  endtask

  task automatic t_stack();
    int tr [21] = '{0, 512, 4000, 4001, 4100, 4101, 4200, 4201, 4300, 4301, 4400, 4401,
                    4500, 4501, 4600, 4601, 4700, 4701, 4502, 4503, 4402};
    do_reset();
    put(0, 0, mk(3'd1, 0, 0, 0, 0, 0, 4000));
    for (int i = 0; i < 7; i++)
      put(1 + i, 4000 + 100 * i, mk(3'd2, 0, 0, 0, 0, 0, 4100 + 100 * i));
    put(8, 4700, mk(3'd3, 0, 0, 0, 0, 0, 0));
    put(9, 4502, mk(3'd3, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 21; i++) begin
      chk("R7", $sformatf("call/ret trace %0d", i), upc_o, tr[i]);
      if (i == 14) chk("R8", "no ovf at six", ovf_err_o, 0);
      if (i == 15) chk("R8", "ovf on seventh", ovf_err_o, 1);
      step();
    end
    chk("R8", "ovf sticky", ovf_err_o, 1);
    chk("R8", "no unf", unf_err_o, 0);
    do_reset();
    put(0, 0, mk(3'd3, 0, 0, 0, 0, 0, 0));
    step(); step();
    chk("R8", "empty pop to 0", upc_o, 0);
    chk("R8", "unf set", unf_err_o, 1);
    step(); step();
    chk("R8", "unf sticky", unf_err_o, 1);
  endtask

  task automatic t_rom();
    do_reset();
    put(0, 0, mk(3'd0, 0, 0, 0, 1, 5, 0));
    step();
    chk("R9", "overlay pc unchanged", upc_o, 512);
    chk("R11", "overlay word", uword_o, exp_rom(5));
    step();
    chk("R9", "pc continues", upc_o, 1024);
    chk("R10", "back to ext", uword_o, 0);
    do_reset();
    put(0, 0, mk(3'd0, 0, 0, 0, 1, 200, 0));
    put(1, 512, 54'h2A << 40);
    step();
    chk("R9", "out of range index", uword_o, 0);
    do_reset();
    put(0, 0, mk(3'd1, 0, 0, 0, 0, 0, 16227));
    step(); step();
    chk("R10", "rom window pc", upc_o, 16227);
    chk("R11", "rom window word", uword_o, exp_rom(3));
    step();
    chk("R10", "rom window next", uword_o, exp_rom(4));
  endtask

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_seq();
    t_jump();
    t_annul();
    t_sources();
    t_stack();
    t_rom();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule